// File: doc/BRIEF.md
# Zero-Fill Flip Chain Scheduler

This block decides which spins of a lattice annealer are forced to invert, and how that set shrinks as annealing proceeds. It holds one flip bit per lattice cell. The bits are arranged as one or more serial sub-chains of equal length. No random source and no temperature multiplier are involved.

Before annealing, a pattern prepared offline is shifted in serially, one bit per clock on each sub-chain. It is usually about half ones. This load can run alongside the loading of weights, biases and spins. During annealing, the controller issues one step command per iteration, after that iteration's spin update. Each step advances every sub-chain by a programmable count k and fills the vacated positions with zeros. The number of asserted flip bits therefore falls, and a larger k cools faster.

The parallel flip vector drives each cell's flip input directly. Once the chain is empty, no further flips occur. A status flag reports that state, and the serial tail of each sub-chain is brought out for read-back.

Top module: `flip_chain_sched`

## Requirements
- R1: After reset every flip bit is 0 and `all_zero` is 1.
- R2: When `load_en` is 1, every sub-chain moves one position toward its higher cell index on the next clock. For sub-chain l, `load_din[l]` enters its lowest cell, l*LEN, where LEN = CELLS/LANES. The bit in the highest cell is discarded.
- R3: `load_dout[l]` always shows the highest cell of sub-chain l, l*LEN+LEN-1. After LEN load clocks, it shows the first bit loaded into that sub-chain.
- R4: When `step` is 1 and `load_en` is 0, every sub-chain moves `shift_k` positions toward its higher index on the next clock. The `shift_k` lowest cells of each sub-chain become 0, and the bits pushed past the top are discarded.
- R5: A step with `shift_k` = 0 leaves the flip vector unchanged. A step with `shift_k` >= LEN clears the whole chain.
- R6: When `load_en` and `step` are both 1 in the same cycle, only the load of R2 takes place.
- R7: With `load_en` and `step` both 0, the flip vector holds its value.
- R8: `all_zero` is 1 exactly when every flip bit is 0.
- R9: A step never increases the number of asserted flip bits. Once the chain is all zeros, it stays all zeros until a load.
- R10: Bits never cross from one sub-chain into another, under either a load or a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Shift one serial bit into each sub-chain |
| load_din | input | LANES | Serial input, one bit per sub-chain |
| step | input | 1 | Per-iteration zero-fill advance command |
| shift_k | input | KW | Positions advanced per step |
| flip_vec | output | CELLS | Flip bit per lattice cell |
| load_dout | output | LANES | Serial tail of each sub-chain |
| all_zero | output | 1 | Chain holds no asserted flip bit |

## Verification
A load and an annealing step can be requested in the same cycle. The bench provokes this by raising `load_en` and `step` together, with a nonzero `shift_k`, on a chain that holds a known pattern. It judges the result at the next clock against a model that applies only the one-position serial shift. Under a step, the same pattern would have moved by k with zero fill. Any step leakage therefore shows up as a mismatch in the flip vector or the serial tails.

// File: rtl/flip_chain_sched.sv
module flip_chain_sched #(
  parameter int CELLS = 16,
  parameter int LANES = 2,
  parameter int KW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [LANES-1:0] load_din,
  input  logic             step,
  input  logic [KW-1:0]    shift_k,
  output logic [CELLS-1:0] flip_vec,
  output logic [LANES-1:0] load_dout,
  output logic             all_zero
);
  localparam int LEN = CELLS / LANES;

  logic [CELLS-1:0] chain_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LEN-1:0] seg, seg_n;
    assign seg = chain_q[l*LEN +: LEN];

    always_comb begin
      seg_n = seg;
      if (load_en)   seg_n = (seg << 1) | LEN'(load_din[l]);
      else if (step) seg_n = seg << shift_k;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[l*LEN +: LEN] <= '0;
      else        chain_q[l*LEN +: LEN] <= seg_n;
    end

    assign load_dout[l] = seg[LEN-1];
  end

  assign flip_vec = chain_q;
  assign all_zero = ~|chain_q;
endmodule

module flip_chain_sched_chk #(
  parameter int CELLS = 16,
  parameter int LANES = 2,
  parameter int KW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_en,
  input logic [LANES-1:0] load_din,
  input logic             step,
  input logic [KW-1:0]    shift_k,
  input logic [CELLS-1:0] flip_vec,
  input logic [LANES-1:0] load_dout,
  input logic             all_zero
);
  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !step) |=> $stable(flip_vec));
  // R2
  load_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> flip_vec[0] == $past(load_din[0]));
  // R4
  step_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && shift_k != '0) |=> !flip_vec[0]);
  // R9
  step_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en) |=> $countones(flip_vec) <= $countones($past(flip_vec)));
  // R9
  zero_absorb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_zero && !load_en) |=> all_zero);
  // R5
  k_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load_en && shift_k == '0) |=> $stable(flip_vec));
endmodule

bind flip_chain_sched flip_chain_sched_chk #(.CELLS(CELLS), .LANES(LANES), .KW(KW)) u_chk (.*);

// File: tb/sim_flip_chain_sched.sv
module sim_flip_chain_sched;
  localparam int CELLS = 16;
  localparam int LANES = 2;
  localparam int KW    = 4;
  localparam int LEN   = CELLS / LANES;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             load_en = 1'b0;
  logic [LANES-1:0] load_din = '0;
  logic             step = 1'b0;
  logic [KW-1:0]    shift_k = '0;
  logic [CELLS-1:0] flip_vec;
  logic [LANES-1:0] load_dout;
  logic             all_zero;

  flip_chain_sched #(.CELLS(CELLS), .LANES(LANES), .KW(KW)) u0 (.*);

  int total = 0;
  int bad = 0;
  logic [CELLS-1:0] mdl = '0;
  logic [CELLS-1:0] exp_q[$];
  string tag_q[$];

  function automatic logic [CELLS-1:0] ref_load(logic [CELLS-1:0] v, logic [LANES-1:0] d);
    logic [CELLS-1:0] r;
    for (int l = 0; l < LANES; l++) begin
      for (int p = LEN-1; p >= 1; p--) r[l*LEN+p] = v[l*LEN+p-1];
      r[l*LEN] = d[l];
    end
    return r;
  endfunction

  function automatic logic [CELLS-1:0] ref_step(logic [CELLS-1:0] v, int k);
    logic [CELLS-1:0] r;
    for (int l = 0; l < LANES; l++)
      for (int p = 0; p < LEN; p++)
        r[l*LEN+p] = (p >= k) ? v[l*LEN+p-k] : 1'b0;
    return r;
  endfunction

  task automatic check_now(string tag, logic [CELLS-1:0] e);
    logic [LANES-1:0] ed;
    for (int l = 0; l < LANES; l++) ed[l] = e[l*LEN+LEN-1];
    total++;
    if (flip_vec !== e || load_dout !== ed || all_zero !== (e == '0)) begin
      bad++;
      $display("FAIL %s: flip=%h dout=%b zero=%b expected flip=%h dout=%b zero=%b",
               tag, flip_vec, load_dout, all_zero, e, ed, (e == '0));
    end
  endtask

  task automatic cyc(logic le, logic [LANES-1:0] d, logic st, int k, string tag);
    @(negedge clk);
    load_en = le; load_din = d; step = st; shift_k = KW'(k);
    if (le) mdl = ref_load(mdl, d);
    else if (st) mdl = ref_step(mdl, k);
    exp_q.push_back(mdl);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check_now(tag_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: run did not complete");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] lf = 8'hB5;
    repeat (3) @(negedge clk);
    #2 check_now("R1 reset", '0);
    rst_n = 1'b1;
    // R2 / R3: load a half-ones pattern over LEN clocks, both lanes
    for (int i = 0; i < LEN; i++) begin
      cyc(1'b1, {lf[0] ^ lf[3], lf[0]}, 1'b0, 0, "R2 load");
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    cyc(1'b0, '0, 1'b0, 0, "R3 tail after full load");
    cyc(1'b0, '0, 1'b0, 0, "R7 idle hold");
    cyc(1'b0, '0, 1'b1, 0, "R5 step k=0");
    cyc(1'b0, '0, 1'b1, 1, "R4 step k=1");
    cyc(1'b1, 2'b11, 1'b1, 3, "R6 load beats step");
    cyc(1'b0, '0, 1'b1, 3, "R4 step k=3");
    cyc(1'b0, '0, 1'b1, 2, "R9 step no rise");
    cyc(1'b0, '0, 1'b1, 15, "R5 step k>=LEN clears");
    cyc(1'b0, '0, 1'b1, 1, "R8 R9 zero stays");
    // R10: ones only in lane 1, lane 0 must stay empty
    for (int i = 0; i < LEN; i++) cyc(1'b1, 2'b10, 1'b0, 0, "R10 lane isolation load");
    cyc(1'b0, '0, 1'b1, 2, "R10 lane isolation step");
    cyc(1'b0, '0, 1'b1, LEN-1, "R4 step k=LEN-1");
    cyc(1'b0, '0, 1'b1, LEN, "R5 step k=LEN");
    cyc(1'b0, '0, 1'b0, 0, "R8 empty flag");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule